// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This unit compares two IEEE-754 operands and turns the result into the four condition flags N, Z, C and V. It also keeps a cumulative invalid-operation flag. Operands may be single or double precision. A double-precision operand arrives as two 32-bit register halves. A two-bit control field, taken from the compare instruction, picks the precision and picks between the quiet and the signalling compare. A separate input makes the second operand the constant zero, and another flushes denormal inputs to zero before the compare.

A one-cycle `start` pulse launches a compare. The flags, the updated invalid flag and a `done` strobe all appear on the next clock edge. Between compares the flags hold their last value. The invalid flag only ever accumulates: once set, it stays set until reset.

Top module: `fp_cmp_flags`

## Requirements
- R1: Equal operands give `nzcv` = 4'b0110 (bit 3 N, bit 2 Z, bit 1 C, bit 0 V).
- R2: When operand A is below operand B, `nzcv` = 4'b1000.
- R3: When operand A is above operand B, `nzcv` = 4'b0010.
- R4: If either operand is a NaN (all-ones exponent, nonzero fraction), the result is unordered and `nzcv` = 4'b0011.
- R5: In the quiet compare (`insn_ctl[0]`=0), the invalid flag is raised only when an operand is a signalling NaN. A NaN is signalling when the operand ANDed with the quiet mask differs from that mask. The mask is 32'h7FC00000 for single precision and 64'h7FF8000000000000 for double precision. A quiet NaN leaves the flag unchanged.
- R6: In the signalling compare (`insn_ctl[0]`=1), the invalid flag is raised on every unordered result.
- R7: `insn_ctl[1]`=0 selects single precision. Only `a_lo` and `b_lo` are used, and `a_hi` and `b_hi` have no effect on the result.
- R8: `insn_ctl[1]`=1 selects double precision. Each operand is {hi, lo}: the `_lo` half is bits 31:0 and the `_hi` half is bits 63:32.
- R9: With `zero_mode`=1, operand B is the constant +0 and `b_lo`/`b_hi` are ignored.
- R10: With `ftz_en`=1, denormal inputs compare as zero. With `ftz_en`=0, denormals compare by their true value.
- R11: +0 and -0 compare equal.
- R12: The invalid flag is sticky. It is ORed with each new result and resets to 0.
- R13: `done` is high in exactly the cycle after a `start` pulse, and `nzcv` changes only in that cycle. After reset, `nzcv`=0, `inv_flag`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to compare |
| insn_ctl | input | 2 | Bit 0: signalling compare; bit 1: double precision |
| zero_mode | input | 1 | Compare operand A against zero |
| ftz_en | input | 1 | Flush denormal inputs to zero |
| a_lo | input | 32 | Operand A, low word (the whole operand in single precision) |
| a_hi | input | 32 | Operand A, high word |
| b_lo | input | 32 | Operand B, low word |
| b_hi | input | 32 | Operand B, high word |
| nzcv | output | 4 | Result flags {N,Z,C,V} |
| inv_flag | output | 1 | Cumulative invalid-operation flag |
| done | output | 1 | Result valid strobe |

## Verification
The assertions assume that `start` arrives only while reset is released, and that the control and operand inputs are stable around the clock edge that samples `start`. The bench changes inputs only on falling edges. It also raises `start` only after reset has been released for at least one cycle. The assertion that links a signalling-compare unordered result to the invalid flag assumes that `insn_ctl` was sampled in the same cycle as `start`. The bench holds `insn_ctl` steady for the whole pulse.

// File: rtl/fp_cmp_pkg.sv
package fp_cmp_pkg;

  localparam int WORD_W  = 32;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int SP_W    = 1 + SP_EXP + SP_FRAC;
  localparam int DP_W    = 1 + DP_EXP + DP_FRAC;
  localparam int MAG_W   = DP_EXP + DP_FRAC;
  localparam int FLAG_W  = 4;

  typedef struct packed {
    logic             sign;
    logic             zero;
    logic             nan;
    logic             snan;
    logic [MAG_W-1:0] mag;
  } opnd_t;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  localparam logic [FLAG_W-1:0] NZCV_EQ = 4'b0110;
  localparam logic [FLAG_W-1:0] NZCV_LT = 4'b1000;
  localparam logic [FLAG_W-1:0] NZCV_GT = 4'b0010;
  localparam logic [FLAG_W-1:0] NZCV_UN = 4'b0011;

  function automatic logic [FLAG_W-1:0] rel_to_nzcv(input rel_e r);
    case (r)
      REL_EQ:  return NZCV_EQ;
      REL_LT:  return NZCV_LT;
      REL_GT:  return NZCV_GT;
      default: return NZCV_UN;
    endcase
  endfunction

endpackage

// File: rtl/fp_operand_classify.sv
module fp_operand_classify
  import fp_cmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int RAW_W = 1 + EXP_W + FRAC_W
) (
  input  logic [RAW_W-1:0] raw,
  input  logic             ftz,
  output opnd_t            info
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              exp_zero;
  logic              frac_nz;

  assign exp_f    = raw[RAW_W-2 -: EXP_W];
  assign frac_f   = raw[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    info      = '0;
    info.sign = raw[RAW_W-1];
    info.nan  = exp_ones & frac_nz;
    // quiet bit is the top fraction bit; clear means signalling
    info.snan = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
    info.zero = exp_zero & (~frac_nz | ftz);
    if (!info.zero) begin
      info.mag = MAG_W'({exp_f, frac_f});
    end
  end

endmodule

// File: rtl/fp_order_compare.sv
module fp_order_compare
  import fp_cmp_pkg::*;
(
  input  opnd_t a,
  input  opnd_t b,
  output rel_e  rel
);

  logic mag_lt;
  logic mag_eq;

  assign mag_lt = a.mag < b.mag;
  assign mag_eq = a.mag == b.mag;

  always_comb begin
    if (a.nan || b.nan) begin
      rel = REL_UN;
    end else if (a.zero && b.zero) begin
      rel = REL_EQ;
    end else if (a.sign != b.sign) begin
      rel = a.sign ? REL_LT : REL_GT;
    end else if (mag_eq) begin
      rel = REL_EQ;
    end else if (mag_lt ^ a.sign) begin
      rel = REL_LT;
    end else begin
      rel = REL_GT;
    end
  end

endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags
  import fp_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        insn_ctl,
  input  logic              zero_mode,
  input  logic              ftz_en,
  input  logic [WORD_W-1:0] a_lo,
  input  logic [WORD_W-1:0] a_hi,
  input  logic [WORD_W-1:0] b_lo,
  input  logic [WORD_W-1:0] b_hi,
  output logic [FLAG_W-1:0] nzcv,
  output logic              inv_flag,
  output logic              done
);

  localparam int NOPS = 2;

  logic              sig_cmp;
  logic              dbl;
  logic [DP_W-1:0]   raw [NOPS];
  opnd_t             opnd [NOPS];
  rel_e              rel;
  logic              inv_now;

  logic [FLAG_W-1:0] nzcv_q, nzcv_d;
  logic              inv_q, inv_d;
  logic              done_q, done_d;

  assign sig_cmp = insn_ctl[0];
  assign dbl     = insn_ctl[1];

  assign raw[0] = {a_hi, a_lo};
  assign raw[1] = zero_mode ? '0 : {b_hi, b_lo};

  for (genvar i = 0; i < NOPS; i++) begin : g_opnd
    opnd_t sp_info;
    opnd_t dp_info;

    fp_operand_classify #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
      .raw  (raw[i][SP_W-1:0]),
      .ftz  (ftz_en),
      .info (sp_info)
    );

    fp_operand_classify #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
      .raw  (raw[i]),
      .ftz  (ftz_en),
      .info (dp_info)
    );

    assign opnd[i] = dbl ? dp_info : sp_info;
  end

  fp_order_compare u_cmp (
    .a   (opnd[0]),
    .b   (opnd[1]),
    .rel (rel)
  );

  assign inv_now = sig_cmp ? (rel == REL_UN) : (opnd[0].snan | opnd[1].snan);

  always_comb begin
    nzcv_d = nzcv_q;
    inv_d  = inv_q;
    done_d = start;
    if (start) begin
      nzcv_d = rel_to_nzcv(rel);
      inv_d  = inv_q | inv_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nzcv_q <= '0;
      inv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      nzcv_q <= nzcv_d;
      inv_q  <= inv_d;
      done_q <= done_d;
    end
  end

  assign nzcv     = nzcv_q;
  assign inv_flag = inv_q;
  assign done     = done_q;

endmodule

// File: rtl/fp_cmp_flags_chk.sv
module fp_cmp_flags_chk
  import fp_cmp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        insn_ctl,
  input logic [FLAG_W-1:0] nzcv,
  input logic              inv_flag,
  input logic              done
);

  a_r13_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (done == $past(start)));

  a_r13_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(start)) |-> $stable(nzcv));

  a_r4_legal_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nzcv == NZCV_EQ || nzcv == NZCV_LT || nzcv == NZCV_GT || nzcv == NZCV_UN));

  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(inv_flag)) |-> inv_flag);

  a_r6_sig_unordered: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nzcv == NZCV_UN && $past(insn_ctl[0])) |-> inv_flag);

  a_r12_rise_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_flag) |-> done);

endmodule

bind fp_cmp_flags fp_cmp_flags_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .insn_ctl (insn_ctl),
  .nzcv     (nzcv),
  .inv_flag (inv_flag),
  .done     (done)
);

// File: tb/tb_fp_cmp_flags.sv
module tb_fp_cmp_flags;

  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 400;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  insn_ctl;
  logic        zero_mode, ftz_en;
  logic [31:0] a_lo, a_hi, b_lo, b_hi;
  logic [3:0]  nzcv;
  logic        inv_flag, done;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_cmp_flags dut (
    .clk(clk), .rst_n(rst_n), .start(start), .insn_ctl(insn_ctl),
    .zero_mode(zero_mode), .ftz_en(ftz_en),
    .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
    .nzcv(nzcv), .inv_flag(inv_flag), .done(done)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] opval(input logic dbl, input logic [31:0] lo, input logic [31:0] hi);
    return dbl ? {hi, lo} : {32'b0, lo};
  endfunction

  function automatic logic is_nan(input logic dbl, input logic [63:0] x);
    if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic logic is_snan(input logic dbl, input logic [63:0] x);
    if (dbl) return is_nan(dbl, x) && ((x & 64'h7FF8000000000000) != 64'h7FF8000000000000);
    return is_nan(dbl, x) && ((x[31:0] & 32'h7FC00000) != 32'h7FC00000);
  endfunction

  // maps a non-NaN value to an unsigned key in numeric order
  function automatic logic [63:0] order_key(input logic dbl, input logic ftz, input logic [63:0] x);
    logic [63:0] m;
    logic        s;
    logic        ez;
    s  = dbl ? x[63] : x[31];
    m  = dbl ? {1'b0, x[62:0]} : {33'b0, x[30:0]};
    ez = dbl ? (x[62:52] == 0) : (x[30:23] == 0);
    if (ez && ftz) m = 0;
    if (m == 0) return 64'h8000000000000000;
    return s ? (64'h8000000000000000 - m) : (64'h8000000000000000 + m);
  endfunction

  function automatic logic [3:0] model(input logic [1:0] ctl, input logic zm, input logic ftz,
                                       input logic [31:0] al, input logic [31:0] ah,
                                       input logic [31:0] bl, input logic [31:0] bh,
                                       output logic inv);
    logic [63:0] a, b, ka, kb;
    logic        dbl;
    dbl = ctl[1];
    a   = opval(dbl, al, ah);
    b   = zm ? 64'h0 : opval(dbl, bl, bh);
    if (is_nan(dbl, a) || is_nan(dbl, b)) begin
      inv = ctl[0] ? 1'b1 : (is_snan(dbl, a) || is_snan(dbl, b));
      return 4'b0011;
    end
    inv = 1'b0;
    ka  = order_key(dbl, ftz, a);
    kb  = order_key(dbl, ftz, b);
    if (ka == kb) return 4'b0110;
    if (ka < kb)  return 4'b1000;
    return 4'b0010;
  endfunction

  function automatic string rel_tag(input logic [3:0] f);
    case (f)
      4'b0110: return "R1";
      4'b1000: return "R2";
      4'b0010: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [63:0] mk(input logic dbl, input int kind);
    logic        s;
    logic [10:0] e;
    logic [51:0] f;
    s = 1'($urandom);
    f = {20'($urandom), $urandom};
    case (kind)
      0: begin e = 0; f = 0; end
      1: begin e = 0; if (f == 0) f = 1; end
      2: e = dbl ? (11'($urandom_range(2046, 1))) : (11'($urandom_range(254, 1)));
      3: begin e = 11'h7FF; f = 0; end
      4: begin e = 11'h7FF; f[51] = 1'b1; f[22] = 1'b1; end
      5: begin e = 11'h7FF; f[51] = 1'b0; f[22] = 1'b0; f[0] = 1'b1; end
      default: e = dbl ? (11'($urandom_range(1025, 1021))) : (11'($urandom_range(129, 125)));
    endcase
    if (dbl) return {s, e, f};
    return {$urandom, s, e[7:0], f[22:0]};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic launch(input logic [1:0] ctl, input logic zm, input logic ftz,
                        input logic [31:0] al, input logic [31:0] ah,
                        input logic [31:0] bl, input logic [31:0] bh);
    insn_ctl = ctl; zero_mode = zm; ftz_en = ftz;
    a_lo = al; a_hi = ah; b_lo = bl; b_hi = bh;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  logic wd_expired = 1'b0;

  initial begin
    #(CLK_PERIOD * 150000);
    wd_expired = 1'b1;
  end

  initial begin
    logic [3:0]  ef;
    logic        ei;
    logic [3:0]  held;
    void'($urandom(32'd20240611));
    insn_ctl = 0; zero_mode = 0; ftz_en = 0;
    a_lo = 0; a_hi = 0; b_lo = 0; b_hi = 0;
    start = 0; rst_n = 0;
    @(negedge clk);
    check("R13 reset nzcv", 64'(nzcv), 64'h0);
    check("R13 reset inv", 64'(inv_flag), 64'h0);
    check("R13 reset done", 64'(done), 64'h0);
    do_reset();

    // random compares, reset before each so inv reflects this compare alone
    for (int n = 0; n < N_RAND && !wd_expired; n++) begin
      logic [1:0]  ctl;
      logic        zm, ftz;
      logic [63:0] a, b;
      int          ka, kb;
      ctl = 2'($urandom);
      zm  = ($urandom_range(7, 0) == 0);
      ftz = 1'($urandom);
      ka  = $urandom_range(7, 0);
      kb  = $urandom_range(7, 0);
      a   = mk(ctl[1], ka);
      b   = (kb == 6) ? a : mk(ctl[1], kb);
      if (kb == 6 && !ctl[1]) b[63:32] = $urandom;
      do_reset();
      ef = model(ctl, zm, ftz, a[31:0], a[63:32], b[31:0], b[63:32], ei);
      launch(ctl, zm, ftz, a[31:0], a[63:32], b[31:0], b[63:32]);
      check("R13 done", 64'(done), 64'h1);
      check(rel_tag(ef), 64'(nzcv), 64'(ef));
      check(ctl[0] ? "R6 inv" : "R5 inv", 64'(inv_flag), 64'(ei));
    end

    // R11: -0 vs +0, single and double
    do_reset();
    launch(2'b00, 0, 0, 32'h80000000, 32'h0, 32'h00000000, 32'h0);
    check("R11 sp -0 == +0", 64'(nzcv), 64'h6);
    launch(2'b10, 0, 0, 32'h0, 32'h80000000, 32'h0, 32'h0);
    check("R11 dp -0 == +0", 64'(nzcv), 64'h6);

    // R9: zero mode ignores b
    launch(2'b00, 1, 0, 32'hBF800000, 32'h0, 32'hC0000000, 32'h0);
    check("R9 -1 vs zero", 64'(nzcv), 64'h8);
    launch(2'b00, 1, 0, 32'h00000000, 32'h0, 32'h7F800001, 32'h0);
    check("R9 snan on b ignored", 64'(nzcv), 64'h6);
    check("R9 snan on b no inv", 64'(inv_flag), 64'h0);

    // R7: single uses low words only
    launch(2'b00, 0, 0, 32'h3F800000, 32'hFFFFFFFF, 32'h3F800000, 32'h00000000);
    check("R7 hi words ignored", 64'(nzcv), 64'h6);
    launch(2'b00, 0, 0, 32'h40000000, 32'h7FF00001, 32'h3F800000, 32'h0);
    check("R7 sp greater", 64'(nzcv), 64'h2);

    // R8: double halves ordering (low word larger but high word smaller)
    launch(2'b10, 0, 0, 32'hFFFFFFFF, 32'h3FF00000, 32'h00000000, 32'h40000000);
    check("R8 hi word dominates", 64'(nzcv), 64'h8);

    // R10: denormal vs zero with and without flush
    launch(2'b00, 0, 0, 32'h00000001, 32'h0, 32'h00000000, 32'h0);
    check("R10 no ftz denorm > 0", 64'(nzcv), 64'h2);
    launch(2'b00, 0, 1, 32'h00000001, 32'h0, 32'h00000000, 32'h0);
    check("R10 ftz denorm == 0", 64'(nzcv), 64'h6);
    launch(2'b10, 0, 1, 32'h0, 32'h80000001, 32'h0, 32'h00000000);
    check("R10 ftz dp -denorm == 0", 64'(nzcv), 64'h6);

    // R5: quiet NaN in quiet compare leaves inv clear
    launch(2'b00, 0, 0, 32'h7FC00000, 32'h0, 32'h3F800000, 32'h0);
    check("R4 qnan unordered", 64'(nzcv), 64'h3);
    check("R5 qnan no inv", 64'(inv_flag), 64'h0);

    // R13: idle cycle holds flags, done low
    held = nzcv;
    insn_ctl = 2'b00; a_lo = 32'hBF800000; b_lo = 32'h3F800000;
    @(negedge clk);
    check("R13 done low when idle", 64'(done), 64'h0);
    check("R13 flags held", 64'(nzcv), 64'(held));

    // R12: sticky after a raise and a clean compare
    launch(2'b01, 0, 0, 32'h7FC00000, 32'h0, 32'h0, 32'h0);
    check("R6 qnan signalling cmp inv", 64'(inv_flag), 64'h1);
    launch(2'b00, 0, 0, 32'h3F800000, 32'h0, 32'h3F800000, 32'h0);
    check("R12 inv sticky", 64'(inv_flag), 64'h1);
    check("R1 after sticky", 64'(nzcv), 64'h6);

    if (wd_expired) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(posedge wd_expired);
    #(CLK_PERIOD * 10);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule